// File: doc/BRIEF.md
# Configurable Audio Serial Port Framer

This block moves multichannel audio samples between parallel per-channel registers and a single-wire serial data link. A bit clock and a frame clock frame the link. The block can generate both clocks itself from the system clock (master), or it can follow clocks supplied by another device (slave). A frame carries two, four or eight channel slots. Each slot is 32 bit-clock periods long. It holds a 24-bit sample sent most significant bit first, followed by zero padding. The first data bit follows the frame-start edge of the frame clock by one bit-clock period.

Seven configuration bits choose the following:
- master or slave operation;
- the channel count;
- a frame clock that is high and low for equal times, or a one-bit-period pulse;
- which bit-clock edge launches new data;
- which frame-clock edge marks the first (left) slot;
- which of two divider settings sets the bit-clock rate in master mode.

Transmit samples are latched once per frame at the frame start. Received samples are presented together with a one-cycle frame strobe once the last active slot has been captured.

The control logic is a two-state machine, with states `HUNT` and `RUN`:
- `HUNT` waits for a frame start and drives the data line low.
- `HUNT_TO_RUN` is taken when a capture edge sees the frame clock pass to its start level.
- `RUN_RESTART` keeps `RUN` and clears the bit position on every further frame start.
- `RUN_OVERRUN` returns to `HUNT` when a frame runs past its nominal length without a new start.

Top module: `aud_sport_framer`

## Requirements
- R1: After reset both clock output enables are low (slave), `sdata_o` is 0, `frame_o` is 0 and `rx_data_o` is all zero.
- R2: With `cfg_i[0]`=1 (master) both clock enables are high and `bclk_o` stays high for HALF_A system clocks when `cfg_i[6]`=0, or for HALF_B when `cfg_i[6]`=1. With `cfg_i[0]`=0, `bclk_o` is held low.
- R3: `cfg_i[2:1]` sets the channel count: 00 gives 2, 01 gives 4, 10 gives 8, and 11 is treated as 2. In master mode one frame-clock period spans 32 times that count in bit-clock periods.
- R4: With `cfg_i[5]`=0 the frame clock holds its start level for half the frame. With `cfg_i[5]`=1 it holds its start level for exactly one bit-clock period.
- R5: `cfg_i[3]` is the frame clock's level in the first slot. 0 means a falling edge starts the frame; 1 means a rising edge starts it.
- R6: `cfg_i[4]`=0 makes `sdata_o` and `lrclk_o` change only after a falling bit-clock edge. `cfg_i[4]`=1 makes them change only after a rising edge. Input data is sampled on the opposite edge.
- R7: Channel k occupies bit positions 32k+1 to 32k+24 after the frame-start edge, MSB first, and `tx_data_i[24k +: 24]` maps to `rx_data_o[24k +: 24]`. A loopback of `sdata_o` to `sdata_i` returns every active channel unchanged.
- R8: `frame_o` pulses for one system clock once per frame, after the last active channel's LSB is captured. `rx_data_o` holds that frame's samples from the same cycle.
- R9: In slave mode the block follows external `bclk_i` and `lrclk_i`. It receives the words presented on `sdata_i` and serialises `tx_data_i` onto `sdata_o` in the slot layout of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_i | input | 7 | Configuration: [0] master, [2:1] channel code, [3] frame-clock polarity, [4] bit-clock polarity, [5] pulse frame clock, [6] alternate rate |
| tx_data_i | input | MAX_CH*SAMPLE_W | Transmit samples, channel k at [k*SAMPLE_W +: SAMPLE_W] |
| rx_data_o | output | MAX_CH*SAMPLE_W | Received samples of the last complete frame |
| frame_o | output | 1 | One-cycle strobe per received frame |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| bclk_i | input | 1 | Bit clock pin, input side |
| bclk_o | output | 1 | Bit clock pin, output side |
| bclk_oe_o | output | 1 | Bit clock pin driver enable |
| lrclk_i | input | 1 | Frame clock pin, input side |
| lrclk_o | output | 1 | Frame clock pin, output side |
| lrclk_oe_o | output | 1 | Frame clock pin driver enable |

## Verification
The bench builds the block with HALF_A=4 and HALF_B=7 and keeps MAX_CH=8. The short, unequal half periods let a full eight-channel frame complete in about two thousand system clocks. They also make the selected divider setting visible in a direct count of the `bclk_o` high time. Master runs loop `sdata_o` back into `sdata_i` under each channel code and each polarity and pulse combination. Slave runs use a bench-generated clock and data stream with 6-cycle half periods, which is slower than the block's internal synchronisers.

// File: rtl/aud_sport_pkg.sv
package aud_sport_pkg;

    typedef struct packed {
        logic       rate_alt;
        logic       lr_pulse;
        logic       bclk_pol;
        logic       lr_pol;
        logic [1:0] ch_code;
        logic       master;
    } port_cfg_t;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_e;

    function automatic logic [3:0] ch_count(input logic [1:0] code);
        case (code)
            2'b01:   return 4'd4;
            2'b10:   return 4'd8;
            default: return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
    parameter int HALF_A    = 8,
    parameter int HALF_B    = 12,
    parameter int SLOT_BITS = 32,
    parameter int MAX_CH    = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       master_i,
    input  logic       rate_alt_i,
    input  logic       lr_pulse_i,
    input  logic       lr_pol_i,
    input  logic [3:0] nch_i,
    input  logic       launch_i,
    output logic       bclk_o,
    output logic       lr_o
);
    localparam int HMAX    = (HALF_A > HALF_B) ? HALF_A : HALF_B;
    localparam int DW      = $clog2(HMAX + 1);
    localparam int SLOT_LG = $clog2(SLOT_BITS);
    localparam int POS_W   = $clog2(SLOT_BITS * MAX_CH) + 1;

    logic [DW-1:0]    div_cnt, half_m1;
    logic [POS_W-1:0] mcnt, mnext, frame_len, last;
    logic             active;

    assign half_m1   = rate_alt_i ? DW'(HALF_B - 1) : DW'(HALF_A - 1);
    assign frame_len = POS_W'(nch_i) << SLOT_LG;
    assign last      = frame_len - 1'b1;
    assign mnext     = (mcnt >= last) ? '0 : mcnt + 1'b1;
    assign active    = lr_pulse_i ? (mnext == '0) : (mnext < (frame_len >> 1));

    // bit clock divider
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_cnt <= '0;
            bclk_o  <= 1'b0;
        end else if (!master_i) begin
            div_cnt <= '0;
            bclk_o  <= 1'b0;
        end else if (div_cnt >= half_m1) begin
            div_cnt <= '0;
            bclk_o  <= ~bclk_o;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // frame clock generator, advances on every launch edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mcnt <= '1;
            lr_o <= 1'b1;
        end else if (!master_i) begin
            mcnt <= last;
            lr_o <= ~lr_pol_i;
        end else if (launch_i) begin
            mcnt <= mnext;
            lr_o <= active ? lr_pol_i : ~lr_pol_i;
        end
    end

    a_r2_slave_bclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master_i |=> (bclk_o == 1'b0));

    a_r6_lr_moves_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_i && $past(master_i) && !$stable(lr_o)) |-> $past(launch_i));

endmodule

// File: rtl/sport_edge.sv
module sport_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic master_i,
    input  logic bclk_pol_i,
    input  logic bclk_int_i,
    input  logic lr_int_i,
    input  logic bclk_pin_i,
    input  logic lrclk_pin_i,
    input  logic sdata_pin_i,
    output logic launch_o,
    output logic capture_o,
    output logic lr_o,
    output logic din_o
);
    logic [1:0] bsync, lsync, dsync;
    logic       b_now, b_prev, rise, fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bsync  <= '0;
            lsync  <= '0;
            dsync  <= '0;
            b_prev <= 1'b0;
        end else begin
            bsync  <= {bsync[0], bclk_pin_i};
            lsync  <= {lsync[0], lrclk_pin_i};
            dsync  <= {dsync[0], sdata_pin_i};
            b_prev <= b_now;
        end
    end

    assign b_now     = master_i ? bclk_int_i : bsync[1];
    assign rise      = b_now & ~b_prev;
    assign fall      = ~b_now & b_prev;
    assign launch_o  = bclk_pol_i ? rise : fall;
    assign capture_o = bclk_pol_i ? fall : rise;
    assign lr_o      = master_i ? lr_int_i : lsync[1];
    assign din_o     = dsync[1];

endmodule

// File: rtl/sport_engine.sv
module sport_engine
    import aud_sport_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24,
    parameter int MAX_CH    = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         launch_i,
    input  logic                         capture_i,
    input  logic                         lr_i,
    input  logic                         din_i,
    input  logic                         lr_pol_i,
    input  logic [3:0]                   nch_i,
    input  logic [MAX_CH*SAMPLE_W-1:0]   tx_i,
    output logic [MAX_CH*SAMPLE_W-1:0]   rx_o,
    output logic                         frame_o,
    output logic                         sdata_o
);
    localparam int SLOT_LG = $clog2(SLOT_BITS);
    localparam int POS_W   = $clog2(SLOT_BITS * MAX_CH) + 1;
    localparam int CH_W    = $clog2(MAX_CH);
    localparam logic [SLOT_LG-1:0] BIT_LIM = SLOT_LG'(SAMPLE_W);
    localparam logic [SLOT_LG-1:0] BIT_TOP = SLOT_LG'(SAMPLE_W - 1);

    eng_state_e state, state_nx;

    logic [MAX_CH-1:0][SAMPLE_W-1:0] tx_buf, work;
    logic [POS_W-1:0]   pos, frame_len, last;
    logic [CH_W-1:0]    slot;
    logic [SLOT_LG-1:0] bitx;
    logic               lr_prev, start, in_range, data_bit, last_bit, pend;

    assign frame_len = POS_W'(nch_i) << SLOT_LG;
    assign last      = frame_len - 1'b1;
    // position after this step is pos+1; its zero-based slot offset is pos
    assign slot      = pos[SLOT_LG +: CH_W];
    assign bitx      = pos[SLOT_LG-1:0];
    assign in_range  = (pos < last);
    assign data_bit  = in_range && (bitx < BIT_LIM);
    assign last_bit  = data_bit && (bitx == BIT_TOP) && (slot == CH_W'(nch_i - 1'b1));
    assign start     = capture_i && (lr_prev != lr_pol_i) && (lr_i == lr_pol_i);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= ST_HUNT;
        else         state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (start) state_nx = ST_RUN;                            // HUNT_TO_RUN
            ST_RUN:  if (capture_i && !start && !in_range) state_nx = ST_HUNT; // RUN_OVERRUN
            default: state_nx = ST_HUNT;
        endcase
    end

    // position, transmit latch and receive shifting
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lr_prev <= 1'b0;
            pos     <= '0;
            tx_buf  <= '0;
            work    <= '0;
            pend    <= 1'b0;
        end else begin
            pend <= 1'b0;
            if (capture_i) lr_prev <= lr_i;
            if (start) begin                                                  // RUN_RESTART
                pos    <= '0;
                tx_buf <= tx_i;
            end else if (capture_i && state == ST_RUN) begin
                if (in_range) pos <= pos + 1'b1;
                if (data_bit) work[slot] <= {work[slot][SAMPLE_W-2:0], din_i};
                if (last_bit) pend <= 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sdata_o <= 1'b0;
            frame_o <= 1'b0;
            rx_o    <= '0;
        end else begin
            frame_o <= pend;
            if (pend) rx_o <= work;
            if (launch_i) begin
                if (state == ST_RUN && data_bit) sdata_o <= tx_buf[slot][BIT_TOP - bitx];
                else                             sdata_o <= 1'b0;
            end
        end
    end

    a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |=> !frame_o);

    a_r6_sdata_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sdata_o) |-> $past(launch_i));

    a_r7_hunt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_HUNT) |-> !sdata_o);

endmodule

// File: rtl/aud_sport_framer.sv
module aud_sport_framer
    import aud_sport_pkg::*;
#(
    parameter int HALF_A    = 8,
    parameter int HALF_B    = 12,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24,
    parameter int MAX_CH    = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [6:0]                 cfg_i,
    input  logic [MAX_CH*SAMPLE_W-1:0] tx_data_i,
    output logic [MAX_CH*SAMPLE_W-1:0] rx_data_o,
    output logic                       frame_o,
    input  logic                       sdata_i,
    output logic                       sdata_o,
    input  logic                       bclk_i,
    output logic                       bclk_o,
    output logic                       bclk_oe_o,
    input  logic                       lrclk_i,
    output logic                       lrclk_o,
    output logic                       lrclk_oe_o
);
    port_cfg_t  cfg;
    logic [3:0] nch;
    logic       bclk_int, lr_int, launch, capture, lr_lvl, din;

    assign cfg        = port_cfg_t'(cfg_i);
    assign nch        = ch_count(cfg.ch_code);
    assign bclk_o     = bclk_int;
    assign lrclk_o    = lr_int;
    assign bclk_oe_o  = cfg.master;
    assign lrclk_oe_o = cfg.master;

    sport_clkgen #(
        .HALF_A(HALF_A), .HALF_B(HALF_B), .SLOT_BITS(SLOT_BITS), .MAX_CH(MAX_CH)
    ) u_clkgen (
        .clk_i(clk_i), .rst_ni(rst_ni), .master_i(cfg.master), .rate_alt_i(cfg.rate_alt),
        .lr_pulse_i(cfg.lr_pulse), .lr_pol_i(cfg.lr_pol), .nch_i(nch), .launch_i(launch),
        .bclk_o(bclk_int), .lr_o(lr_int)
    );

    sport_edge u_edge (
        .clk_i(clk_i), .rst_ni(rst_ni), .master_i(cfg.master), .bclk_pol_i(cfg.bclk_pol),
        .bclk_int_i(bclk_int), .lr_int_i(lr_int), .bclk_pin_i(bclk_i), .lrclk_pin_i(lrclk_i),
        .sdata_pin_i(sdata_i), .launch_o(launch), .capture_o(capture), .lr_o(lr_lvl),
        .din_o(din)
    );

    sport_engine #(
        .SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W), .MAX_CH(MAX_CH)
    ) u_engine (
        .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .capture_i(capture),
        .lr_i(lr_lvl), .din_i(din), .lr_pol_i(cfg.lr_pol), .nch_i(nch), .tx_i(tx_data_i),
        .rx_o(rx_data_o), .frame_o(frame_o), .sdata_o(sdata_o)
    );

endmodule

// File: tb/aud_sport_framer_test.sv
module aud_sport_framer_test;
    localparam int MAXC = 8;
    localparam int SW   = 24;
    localparam int VEC  = MAXC * SW;
    localparam int HA   = 4;
    localparam int HB   = 7;
    localparam int SH   = 6;

    typedef struct {
        logic [VEC-1:0] d;
        int             n;
    } exp_t;

    logic           clk = 0, rst_n = 0;
    logic [6:0]     cfg = '0;
    logic [VEC-1:0] tx = '0, rx;
    logic           frame, sdo, bclk_o, bclk_oe, lrclk_o, lrclk_oe;
    logic           bclk_drv = 0, lr_drv = 0, sd_drv = 0, loop = 0;
    logic           sdi;

    int   checks = 0, failures = 0, strobes = 0;
    exp_t q[$];
    logic pol_on = 0, pol_lvl = 0, lr_s = 0, sd_s = 0;

    assign sdi = loop ? sdo : sd_drv;

    always #5 clk = ~clk;

    aud_sport_framer #(.HALF_A(HA), .HALF_B(HB)) uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .tx_data_i(tx), .rx_data_o(rx),
        .frame_o(frame), .sdata_i(sdi), .sdata_o(sdo), .bclk_i(bclk_drv), .bclk_o(bclk_o),
        .bclk_oe_o(bclk_oe), .lrclk_i(lr_drv), .lrclk_o(lrclk_o), .lrclk_oe_o(lrclk_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] wpat(input int k, input int s);
        return SW'((s * 32'h9E3779) ^ (k * 32'h5A5A13) ^ 32'h00C3A5F1);
    endfunction

    function automatic logic [6:0] mk_cfg(input logic m, input logic [1:0] ch, input logic lp,
                                          input logic bp, input logic pu, input logic alt);
        return {alt, pu, bp, lp, ch, m};
    endfunction

    // scoreboard monitor and clock-edge discipline monitor (R8, R7, R9, R6)
    always @(negedge clk) begin
        if (rst_n && frame) begin
            strobes++;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int k = 0; k < e.n; k++)
                    chk($sformatf("R7/R9 rx channel %0d", k), 32'(rx[k*SW +: SW]), 32'(e.d[k*SW +: SW]));
            end
        end
        if (pol_on) begin
            if (lrclk_o !== lr_s) chk("R6 lrclk change edge", 32'(bclk_o), 32'(pol_lvl));
            if (sdo !== sd_s)     chk("R6 sdata change edge", 32'(bclk_o), 32'(pol_lvl));
        end
        lr_s = lrclk_o;
        sd_s = sdo;
    end

    task automatic do_reset(input logic [6:0] c);
        rst_n = 0;
        cfg   = c;
        repeat (4) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic fill_tx(input int n, input int seed, output logic [VEC-1:0] v);
        v = '0;
        for (int k = 0; k < n; k++) v[k*SW +: SW] = wpat(k, seed);
    endtask

    task automatic drain(input int lim, input string req);
        int c = 0;
        while (q.size() > 0 && c < lim) begin
            @(negedge clk);
            c++;
        end
        chk(req, 32'(q.size()), 32'd0);
    endtask

    task automatic measure_half(output int h);
        while (bclk_o !== 1'b0) @(negedge clk);
        while (bclk_o !== 1'b1) @(negedge clk);
        h = 0;
        while (bclk_o === 1'b1) begin
            @(negedge clk);
            h++;
        end
    endtask

    task automatic measure_lr(input logic pol, output int per, output int act);
        logic prev;
        int   cnt;
        prev = lrclk_o;
        forever begin
            @(negedge clk);
            if (prev !== pol && lrclk_o === pol) break;
            prev = lrclk_o;
        end
        prev = lrclk_o;
        cnt  = 0;
        act  = -1;
        forever begin
            @(negedge clk);
            cnt++;
            if (act < 0 && lrclk_o !== pol) act = cnt;
            if (prev !== pol && lrclk_o === pol) break;
            prev = lrclk_o;
        end
        per = cnt;
    endtask

    task automatic run_master(input logic [1:0] ch, input int n, input logic lp, input logic bp,
                              input logic pu, input logic alt, input int seed);
        logic [VEC-1:0] v;
        exp_t e;
        int   h, per, act, half;
        half = alt ? HB : HA;
        fill_tx(n, seed, v);
        tx   = v;
        loop = 1;
        do_reset(mk_cfg(1'b1, ch, lp, bp, pu, alt));
        chk("R2 bclk driver enable", 32'(bclk_oe), 32'd1);
        chk("R2 lrclk driver enable", 32'(lrclk_oe), 32'd1);
        e.d = v;
        e.n = n;
        q.push_back(e);
        pol_lvl = bp;
        pol_on  = 1;
        drain(4 * 64 * n * half, "R8 master frame strobe seen");
        measure_half(h);
        chk("R2 bclk half period", 32'(h), 32'(half));
        measure_lr(lp, per, act);
        chk("R3/R5 frame clock period", 32'(per), 32'(64 * n * half));
        chk("R4/R5 start level width", 32'(act), pu ? 32'(2 * half) : 32'(32 * n * half));
        pol_on = 0;
    endtask

    task automatic run_slave(input logic [1:0] ch, input int n, input logic lp, input logic bp,
                             input int seed);
        logic [VEC-1:0] v, w;
        logic [SW-1:0]  rec[MAXC];
        exp_t e;
        int   fl;
        fl = 32 * n;
        fill_tx(n, seed, v);
        fill_tx(n, seed + 77, w);
        tx       = v;
        loop     = 0;
        bclk_drv = ~bp;
        lr_drv   = ~lp;
        sd_drv   = 0;
        do_reset(mk_cfg(1'b0, ch, lp, bp, 1'b0, 1'b0));
        chk("R2 slave bclk not driven", 32'(bclk_oe), 32'd0);
        for (int k = 0; k < MAXC; k++) rec[k] = '0;
        for (int f = 0; f < 3; f++) begin
            e.d = w;
            e.n = n;
            q.push_back(e);
        end
        strobes = 0;
        bclk_drv = bp;
        repeat (SH) @(negedge clk);
        bclk_drv = ~bp;
        repeat (SH) @(negedge clk);
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < fl; p++) begin
                bclk_drv = bp;
                lr_drv   = (p < fl / 2) ? lp : ~lp;
                sd_drv   = 1'b0;
                if (p > 0 && ((p - 1) % 32) < SW)
                    sd_drv = w[((p - 1) / 32) * SW + (SW - 1 - ((p - 1) % 32))];
                repeat (SH) @(negedge clk);
                bclk_drv = ~bp;
                if (f == 1 && p > 0 && ((p - 1) % 32) < SW)
                    rec[(p - 1) / 32] = {rec[(p - 1) / 32][SW-2:0], sdo};
                repeat (SH) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        for (int k = 0; k < n; k++)
            chk($sformatf("R9 slave tx channel %0d", k), 32'(rec[k]), 32'(v[k*SW +: SW]));
        chk("R8 one strobe per frame", 32'(strobes), 32'd3);
        chk("R8 slave queue drained", 32'(q.size()), 32'd0);
        q.delete();
    endtask

    initial begin
        #(150000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 bclk enable in reset", 32'(bclk_oe), 32'd0);
        chk("R1 lrclk enable in reset", 32'(lrclk_oe), 32'd0);
        chk("R1 sdata in reset", 32'(sdo), 32'd0);
        chk("R1 frame in reset", 32'(frame), 32'd0);
        chk("R1 rx in reset", 32'(rx[31:0] | rx[VEC-1:VEC-32]), 32'd0);
        rst_n = 1;
        repeat (20) @(negedge clk);
        chk("R2 slave bclk held low", 32'(bclk_o), 32'd0);

        run_master(2'b00, 2, 1'b0, 1'b0, 1'b0, 1'b0, 3);   // R3 stereo, 50% duty
        run_master(2'b10, 8, 1'b1, 1'b1, 1'b1, 1'b0, 11);  // R3 TDM8, R4 pulse, R5 rising start
        run_master(2'b01, 4, 1'b1, 1'b0, 1'b0, 1'b1, 21);  // R3 TDM4, R2 alternate rate
        run_master(2'b11, 2, 1'b0, 1'b1, 1'b1, 1'b0, 33);  // R3 reserved code as stereo
        q.delete();
        run_slave(2'b00, 2, 1'b0, 1'b0, 45);                // R9 stereo
        run_slave(2'b01, 4, 1'b1, 1'b1, 57);                // R9 TDM4 inverted polarities

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule